// File: doc/BRIEF.md
# Conditional ALU Execute Unit

This block runs one 32-bit data-processing instruction word per cycle. It reads two source registers through a combinational register-file read port and keeps a four-bit status register of its own, holding negative, zero, carry and overflow. Each accepted word goes through four steps:

- The 4-bit condition field is tested against the current status bits.
- If the test passes, the second operand is formed. It is either an 8-bit immediate rotated into place, or a register value shifted by an amount held in the word.
- One of sixteen ALU operations is applied.
- The block then writes the destination register, updates the status bits, or does both.

The write request and the status bits come out of registers, one clock after the word is presented. The surrounding pipeline owns the register file. It applies the write request, and it drives `rf_rn_data` and `rf_rm_data` in the same cycle as the word, from the read indices that the block puts out. Compare-class operations change only the status bits. A word whose condition fails leaves no trace.

Top module: `cond_alu_exec`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its outputs: after that edge `wr_en` is 0 and `flags` is 4'b0000. The status bits are ordered `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V.
- R2: The condition code is in `instr[31:28]`. Its encodings are:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C & !Z
  - 9: !C | Z
  - A: N==V
  - B: N!=V
  - C: !Z & N==V
  - D: Z | N!=V
  - E: always
  - F: never

  A word whose condition is false produces no write and no change to `flags`.
- R3: The operation code is in `instr[24:21]`. Its encodings are:
  - 0: Rn AND op2
  - 1: XOR
  - 2: Rn-op2
  - 3: op2-Rn
  - 4: Rn+op2
  - 5: Rn+op2+C
  - 6: Rn-op2-!C
  - 7: op2-Rn-!C
  - 8: test AND
  - 9: test XOR
  - A: compare subtract
  - B: compare add
  - C: OR
  - D: op2
  - E: Rn AND NOT op2
  - F: NOT op2

  `rf_rn_addr` is `instr[19:16]` and `rf_rm_addr` is `instr[3:0]`, both combinational. An executed word sets `wr_en`, with `wr_addr`=`instr[15:12]` and `wr_data`=result, one clock after it is presented.
- R4: When `instr[25]`=1, op2 is `instr[7:0]` rotated right by 2*`instr[11:8]`. The shifter carry is bit 31 of op2, or the current C when the rotate field is 0.
- R5: When `instr[25]`=0, op2 is Rm shifted by amount `instr[11:7]`. The shift type is `instr[6:5]`: 0 = LSL, 1 = LSR, 2 = ASR, 3 = ROR. The carry is the last bit shifted out. An amount of 0 has special meanings:
  - LSL: the value passes unchanged with carry C.
  - LSR: a shift by 32, giving 0 with carry Rm[31].
  - ASR: a shift by 32, giving all copies of Rm[31] with carry Rm[31].
  - ROR: a one-bit rotate through C, with carry Rm[0].
- R6: For the arithmetic operations (2-7, A, B), N and Z follow the result. C is the carry out of additions and the inverted borrow of subtractions. V is signed overflow.
- R7: For the logical operations (0, 1, 8, 9, C-F), N and Z follow the result, C is the shifter carry, and V keeps its value.
- R8: When `instr[20]`=0 and the operation is not 8-B, `flags` does not change.
- R9: Operations 8-B never write a register, and they update `flags` whatever the value of `instr[20]`.
- R10: Some words have no effect at all: no write and no change to `flags`. These are the cycles with `issue_valid` low, words with `instr[27:26]`≠00, and register-form words (`instr[25]`=0) with `instr[4]`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | `instr` holds a word to execute this cycle |
| instr | input | 32 | Instruction word |
| rf_rn_addr | output | 4 | First source register index |
| rf_rn_data | input | 32 | First source register value, same cycle |
| rf_rm_addr | output | 4 | Shifted source register index |
| rf_rm_data | input | 32 | Shifted source register value, same cycle |
| wr_en | output | 1 | Registered write request |
| wr_addr | output | 4 | Registered destination index |
| wr_data | output | 32 | Registered result |
| flags | output | 4 | Status bits {N,Z,C,V} |

## Verification
Any wrong status bit shows up one cycle later, at the latest, on `flags`. It also steers later words: a bad C corrupts the next carry-in, rotate-through-carry or conditional decision. A wrong condition decision shows as a missing or extra `wr_en` in the cycle after the word. A shifter fault shows as a wrong `wr_data` or a wrong C from a logical operation. The bench therefore chains random words so that each word's conditions and carries depend on earlier results. It also checks the zero-amount shift meanings and the overflow boundaries directly.

// File: rtl/cae_pkg.sv
package cae_pkg;
  localparam int XLEN    = 32;
  localparam int INSN_W  = 32;
  localparam int RIDX_W  = 4;
  localparam int FLAG_W  = 4;
  localparam int IMM_W   = 8;
  localparam int ROT_W   = 4;
  localparam int SAMT_W  = 5;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic is_compare_op(input alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/cae_cond_eval.sv
module cae_cond_eval
  import cae_pkg::*;
(
  input  logic [3:0] cond,
  input  nzcv_t      st,
  output logic       pass
);
  always_comb begin
    case (cond)
      4'h0:    pass = st.z;
      4'h1:    pass = !st.z;
      4'h2:    pass = st.c;
      4'h3:    pass = !st.c;
      4'h4:    pass = st.n;
      4'h5:    pass = !st.n;
      4'h6:    pass = st.v;
      4'h7:    pass = !st.v;
      4'h8:    pass = st.c && !st.z;
      4'h9:    pass = !st.c || st.z;
      4'hA:    pass = (st.n == st.v);
      4'hB:    pass = (st.n != st.v);
      4'hC:    pass = !st.z && (st.n == st.v);
      4'hD:    pass = st.z || (st.n != st.v);
      4'hE:    pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/cae_operand2.sv
module cae_operand2
  import cae_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic              imm_sel,
  input  logic [11:0]       field,
  input  logic [DATA_W-1:0] rm_val,
  input  logic              c_in,
  output logic [DATA_W-1:0] op2,
  output logic              sh_carry
);
  localparam int AMT_W = SAMT_W + 1;
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [SAMT_W-1:0] rot_amt;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] imm_rot;

  assign rot_amt = {field[IMM_W +: ROT_W], 1'b0};
  assign imm_ext = DATA_W'(field[IMM_W-1:0]);
  assign imm_rot = (imm_ext >> rot_amt) | (imm_ext << (FULL - {1'b0, rot_amt}));

  logic [SAMT_W-1:0] amt;
  shift_kind_e       kind;
  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] reg_val;
  logic              reg_c;

  assign amt  = field[11:7];
  assign kind = shift_kind_e'(field[6:5]);

  always_comb begin
    wide    = '0;
    reg_val = rm_val;
    reg_c   = c_in;
    case (kind)
      SH_LSL: begin
        if (amt != '0) begin
          wide    = {1'b0, rm_val} << amt;
          reg_val = wide[DATA_W-1:0];
          reg_c   = wide[DATA_W];
        end
      end
      SH_LSR: begin
        if (amt == '0) begin
          reg_val = '0;
          reg_c   = rm_val[DATA_W-1];
        end else begin
          wide    = {rm_val, 1'b0} >> amt;
          reg_val = wide[DATA_W:1];
          reg_c   = wide[0];
        end
      end
      SH_ASR: begin
        if (amt == '0) begin
          reg_val = {DATA_W{rm_val[DATA_W-1]}};
          reg_c   = rm_val[DATA_W-1];
        end else begin
          wide    = $unsigned($signed({rm_val, 1'b0}) >>> amt);
          reg_val = wide[DATA_W:1];
          reg_c   = wide[0];
        end
      end
      default: begin
        if (amt == '0) begin
          reg_val = {c_in, rm_val[DATA_W-1:1]};
          reg_c   = rm_val[0];
        end else begin
          reg_val = (rm_val >> amt) | (rm_val << (FULL - {1'b0, amt}));
          reg_c   = reg_val[DATA_W-1];
        end
      end
    endcase
  end

  always_comb begin
    if (imm_sel) begin
      op2      = imm_rot;
      sh_carry = (rot_amt == '0) ? c_in : imm_rot[DATA_W-1];
    end else begin
      op2      = reg_val;
      sh_carry = reg_c;
    end
  end
endmodule

// File: rtl/cae_alu_core.sv
module cae_alu_core
  import cae_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sh_c,
  input  logic              c_in,
  input  logic              v_in,
  output logic [DATA_W-1:0] result,
  output nzcv_t             st_out
);
  logic              arith;
  logic [DATA_W-1:0] x, y;
  logic              cin;
  logic [DATA_W:0]   sum;
  logic              ovf;

  always_comb begin
    arith = 1'b1;
    x     = a;
    y     = b;
    cin   = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin y = ~b; cin = 1'b1; end
      OP_RSB:         begin x = b; y = ~a; cin = 1'b1; end
      OP_ADD, OP_CMN: begin end
      OP_ADC:         cin = c_in;
      OP_SBC:         begin y = ~b; cin = c_in; end
      OP_RSC:         begin x = b; y = ~a; cin = c_in; end
      default:        arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  assign ovf = (x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);

  always_comb begin
    case (op)
      OP_AND, OP_TST: result = a & b;
      OP_EOR, OP_TEQ: result = a ^ b;
      OP_ORR:         result = a | b;
      OP_MOV:         result = b;
      OP_BIC:         result = a & ~b;
      OP_MVN:         result = ~b;
      default:        result = sum[DATA_W-1:0];
    endcase
  end

  always_comb begin
    st_out.n = result[DATA_W-1];
    st_out.z = (result == '0);
    st_out.c = arith ? sum[DATA_W] : sh_c;
    st_out.v = arith ? ovf : v_in;
  end
endmodule

// File: rtl/cond_alu_exec.sv
module cond_alu_exec
  import cae_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int IDX_W  = RIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [INSN_W-1:0] instr,
  output logic [IDX_W-1:0]  rf_rn_addr,
  input  logic [DATA_W-1:0] rf_rn_data,
  output logic [IDX_W-1:0]  rf_rm_addr,
  input  logic [DATA_W-1:0] rf_rm_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags
);
  nzcv_t             st_q;
  alu_op_e           op;
  logic              cond_pass;
  logic              class_ok;
  logic              commit;
  logic              cmp_only;
  logic [DATA_W-1:0] op2;
  logic              sh_c;
  logic [DATA_W-1:0] alu_res;
  nzcv_t             alu_st;

  assign op         = alu_op_e'(instr[24:21]);
  assign rf_rn_addr = instr[19:16];
  assign rf_rm_addr = instr[3:0];
  assign class_ok   = (instr[27:26] == 2'b00) && (instr[25] || !instr[4]);
  assign cmp_only   = is_compare_op(op);
  assign commit     = issue_valid && class_ok && cond_pass;

  cae_cond_eval u_cond (
    .cond (instr[31:28]),
    .st   (st_q),
    .pass (cond_pass)
  );

  cae_operand2 #(.DATA_W(DATA_W)) u_op2 (
    .imm_sel  (instr[25]),
    .field    (instr[11:0]),
    .rm_val   (rf_rm_data),
    .c_in     (st_q.c),
    .op2      (op2),
    .sh_carry (sh_c)
  );

  cae_alu_core #(.DATA_W(DATA_W)) u_alu (
    .op     (op),
    .a      (rf_rn_data),
    .b      (op2),
    .sh_c   (sh_c),
    .c_in   (st_q.c),
    .v_in   (st_q.v),
    .result (alu_res),
    .st_out (alu_st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      st_q    <= '0;
    end else begin
      wr_en <= commit && !cmp_only;
      if (commit && !cmp_only) begin
        wr_addr <= instr[15:12];
        wr_data <= alu_res;
      end
      if (commit && (instr[20] || cmp_only))
        st_q <= alu_st;
    end
  end

  assign flags = st_q;
endmodule

// File: rtl/cae_checker.sv
module cae_checker (
  input logic        clk,
  input logic        rst,
  input logic        issue_valid,
  input logic [31:0] instr,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [3:0]  flags
);
  logic logic_op;
  assign logic_op = (instr[24:21] == 4'h0) || (instr[24:21] == 4'h1) ||
                    (instr[24:21] >= 4'hC);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!wr_en && flags == 4'b0000));

  assert_code_f_inert_R2: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && instr[31:28] == 4'hF) |=> (!wr_en && $stable(flags)));

  assert_dest_index_R3: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> (!wr_en || wr_addr == $past(instr[15:12])));

  assert_logic_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && instr[27:25] == 3'b001 && instr[31:28] == 4'hE &&
     instr[20] && logic_op)
    |=> (flags[2] == (wr_data == 32'd0) && flags[3] == wr_data[31] &&
         flags[0] == $past(flags[0])));

  assert_sflag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !instr[20] && instr[24:23] != 2'b10) |=> $stable(flags));

  assert_test_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && instr[24:23] == 2'b10) |=> !wr_en);

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!issue_valid || instr[27:26] != 2'b00) |=> (!wr_en && $stable(flags)));
endmodule

bind cond_alu_exec cae_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .instr       (instr),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .flags       (flags)
);

// File: tb/cond_alu_exec_tb_top.sv
module cond_alu_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0]  rf_rn_addr, rf_rm_addr, wr_addr;
  logic [31:0] rf_rn_data, rf_rm_data, wr_data;
  logic        wr_en;
  logic [3:0]  flags;

  logic [31:0] rf [16];
  logic [3:0]  mflags = 4'b0000;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign rf_rn_data = rf[rf_rn_addr];
  assign rf_rm_data = rf[rf_rm_addr];

  cond_alu_exec dut_i (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
    .rf_rn_addr(rf_rn_addr), .rf_rn_data(rf_rn_data),
    .rf_rm_addr(rf_rm_addr), .rf_rm_data(rf_rm_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .flags(flags)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;          4'h1: return !z;
      4'h2: return cy;         4'h3: return !cy;
      4'h4: return n;          4'h5: return !n;
      4'h6: return v;          4'h7: return !v;
      4'h8: return cy & !z;    4'h9: return !cy | z;
      4'hA: return n == v;     4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // returns {carry, value}
  function automatic logic [32:0] op2_ref(input logic [31:0] ins,
                                          input logic [31:0] rm, input logic cin);
    logic [63:0] t;
    logic [31:0] val;
    logic        c;
    int          n;
    if (ins[25]) begin
      n   = 2 * int'(ins[11:8]);
      t   = {24'd0, ins[7:0], 24'd0, ins[7:0]} >> n;
      val = t[31:0];
      c   = (n == 0) ? cin : val[31];
    end else begin
      n = int'(ins[11:7]);
      case (ins[6:5])
        2'd0: begin
          if (n == 0) begin val = rm; c = cin; end
          else begin t = {32'd0, rm} << n; val = t[31:0]; c = t[32]; end
        end
        2'd1: begin
          if (n == 0) n = 32;
          t = {32'd0, rm} >> n; val = t[31:0]; c = rm[n-1];
        end
        2'd2: begin
          if (n == 0) n = 32;
          t = {{32{rm[31]}}, rm} >> n; val = t[31:0]; c = rm[n-1];
        end
        default: begin
          if (n == 0) begin val = {cin, rm[31:1]}; c = rm[0]; end
          else begin t = {rm, rm} >> n; val = t[31:0]; c = val[31]; end
        end
      endcase
    end
    return {c, val};
  endfunction

  // returns {c, v, result}
  function automatic logic [33:0] add_ref(input logic [31:0] x, y, input logic ci);
    logic [63:0] s;
    logic [31:0] r;
    longint      sl;
    s  = 64'(x) + 64'(y) + 64'(ci);
    r  = s[31:0];
    sl = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
    return {s[32], sl != longint'($signed(r)), r};
  endfunction

  function automatic logic [33:0] sub_ref(input logic [31:0] x, y, input logic bi);
    logic [31:0] r;
    longint      sl;
    r  = x - y - 32'(bi);
    sl = longint'($signed(x)) - longint'($signed(y)) - longint'(bi);
    return {64'(x) >= 64'(y) + 64'(bi), sl != longint'($signed(r)), r};
  endfunction

  // returns {we, flag_update, flags[3:0], data[31:0]}
  function automatic logic [37:0] exec_ref(input logic [31:0] ins, input logic [31:0] a,
                                           input logic [31:0] rm, input logic [3:0] f);
    logic [32:0] o2;
    logic [33:0] ar;
    logic [31:0] b, r;
    logic        logical, test;
    if (ins[27:26] != 2'b00 || (!ins[25] && ins[4]) || !cond_ok(ins[31:28], f))
      return {2'b00, f, 32'd0};
    o2 = op2_ref(ins, rm, f[1]);
    b  = o2[31:0];
    logical = 1'b1;
    ar = '0;
    r  = '0;
    case (ins[24:21])
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC:       r = a | b;
      4'hD:       r = b;
      4'hE:       r = a & ~b;
      4'hF:       r = ~b;
      4'h2, 4'hA: begin logical = 0; ar = sub_ref(a, b, 1'b0); end
      4'h3:       begin logical = 0; ar = sub_ref(b, a, 1'b0); end
      4'h4, 4'hB: begin logical = 0; ar = add_ref(a, b, 1'b0); end
      4'h5:       begin logical = 0; ar = add_ref(a, b, f[1]); end
      4'h6:       begin logical = 0; ar = sub_ref(a, b, !f[1]); end
      default:    begin logical = 0; ar = sub_ref(b, a, !f[1]); end
    endcase
    if (!logical) r = ar[31:0];
    test = (ins[24:23] == 2'b10);
    return {!test, ins[20] | test,
            r[31], r == 32'd0, logical ? o2[32] : ar[33], logical ? f[0] : ar[32], r};
  endfunction

  function automatic logic [31:0] dp(input logic [3:0] c, input logic i, input logic [3:0] op,
                                     input logic s, input logic [3:0] rn, input logic [3:0] rd,
                                     input logic [11:0] o2);
    return {c, 2'b00, i, op, s, rn, rd, o2};
  endfunction

  function automatic logic [11:0] shreg(input logic [4:0] amt, input logic [1:0] kind,
                                        input logic [3:0] rm);
    return {amt, kind, 1'b0, rm};
  endfunction

  // drives one word just after a falling edge, samples at the next falling edge
  task automatic run(input logic v, input logic [31:0] ins, input string tag);
    logic [37:0] e;
    issue_valid = v;
    instr       = ins;
    #1;
    check(rf_rn_addr == ins[19:16] && rf_rm_addr == ins[3:0], "R3 read index",
          {24'd0, rf_rn_addr, rf_rm_addr}, {24'd0, ins[19:16], ins[3:0]});
    e = v ? exec_ref(ins, rf[ins[19:16]], rf[ins[3:0]], mflags) : {2'b00, mflags, 32'd0};
    @(posedge clk);
    @(negedge clk);
    check(wr_en == e[37], {tag, " wr_en"}, 32'(wr_en), 32'(e[37]));
    if (e[37]) begin
      check(wr_addr == ins[15:12], {tag, " wr_addr"}, 32'(wr_addr), 32'(ins[15:12]));
      check(wr_data == e[31:0], {tag, " wr_data"}, wr_data, e[31:0]);
      rf[ins[15:12]] = e[31:0];
    end
    if (e[36]) mflags = e[35:32];
    check(flags == mflags, {tag, " flags"}, 32'(flags), 32'(mflags));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] ins;
    void'($urandom(32'd2024));
    for (int k = 0; k < 16; k++) rf[k] = $urandom;
    rf[1] = 32'd5;
    rf[4] = 32'h7FFF_FFFF;
    rf[5] = 32'h8000_0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wr_en == 1'b0, "R1 reset wr_en", 32'(wr_en), 32'd0);
    check(flags == 4'b0000, "R1 reset flags", 32'(flags), 32'd0);
    rst = 1'b0;

    // R4: 0xFF rotated right by 8
    run(1, dp(4'hE, 1, 4'hD, 1, 4'h0, 4'h2, {4'h4, 8'hFF}), "R4 imm rotate");
    check(wr_data == 32'hFF00_0000, "R4 rotated value", wr_data, 32'hFF00_0000);
    check(flags == 4'b1010, "R4 carry from bit31", 32'(flags), 32'hA);
    run(1, dp(4'hE, 1, 4'hD, 1, 4'h0, 4'h3, {4'h0, 8'h01}), "R4 rot0");
    check(flags == 4'b0010, "R4 rot0 keeps C", 32'(flags), 32'h2);
    // R6: equal subtract and signed overflow
    run(1, dp(4'hE, 0, 4'h2, 1, 4'h1, 4'h3, shreg(5'd0, 2'd0, 4'h1)), "R6 sub equal");
    check(flags == 4'b0110, "R6 Z and no-borrow C", 32'(flags), 32'h6);
    run(1, dp(4'hE, 1, 4'h4, 1, 4'h4, 4'h6, {4'h0, 8'h01}), "R6 add overflow");
    check(flags == 4'b1001, "R6 N and V on overflow", 32'(flags), 32'h9);
    // R5: zero-amount shift meanings
    run(1, dp(4'hE, 0, 4'hD, 1, 4'h0, 4'h7, shreg(5'd0, 2'd1, 4'h5)), "R5 LSR32");
    check(flags == 4'b0111 && wr_data == 32'd0, "R5 LSR32 flags", 32'(flags), 32'h7);
    run(1, dp(4'hE, 0, 4'hD, 1, 4'h0, 4'h7, shreg(5'd0, 2'd2, 4'h5)), "R5 ASR32");
    check(wr_data == 32'hFFFF_FFFF, "R5 ASR32 value", wr_data, 32'hFFFF_FFFF);
    run(1, dp(4'hE, 0, 4'hD, 1, 4'h0, 4'h7, shreg(5'd0, 2'd3, 4'h5)), "R5 RRX");
    check(wr_data == 32'hC000_0000, "R5 RRX value", wr_data, 32'hC000_0000);
    // R2: code F never, EQ/NE decisions
    run(1, dp(4'hF, 1, 4'hD, 1, 4'h0, 4'h8, 12'h0), "R2 code F");
    // R9: compare with S clear updates flags, no write
    run(1, dp(4'hE, 1, 4'hA, 0, 4'h1, 4'h0, {4'h0, 8'h05}), "R9 compare S=0");
    check(flags == 4'b0110, "R9 compare flags", 32'(flags), 32'h6);
    // R8: S clear leaves flags
    run(1, dp(4'hE, 1, 4'h4, 0, 4'h1, 4'h9, {4'h0, 8'h01}), "R8 add S=0");
    check(wr_data == 32'd6, "R8 add result", wr_data, 32'd6);
    run(1, dp(4'h0, 1, 4'hD, 0, 4'h0, 4'hA, {4'h0, 8'h07}), "R2 EQ taken");
    run(1, dp(4'h1, 1, 4'hD, 0, 4'h0, 4'hA, {4'h0, 8'h09}), "R2 NE skipped");
    // R10: idle, other class, register-specified shift
    run(0, dp(4'hE, 1, 4'hD, 1, 4'h0, 4'hB, 12'h0), "R10 idle");
    run(1, {4'hE, 2'b01, 1'b1, 4'hD, 1'b1, 8'h0B, 12'h0}, "R10 other class");
    run(1, dp(4'hE, 0, 4'hD, 1, 4'h0, 4'hB, 12'h015), "R10 reg-shift form");

    for (int k = 0; k < 3000; k++) begin
      ins = $urandom;
      if ($urandom % 20 != 0) ins[27:26] = 2'b00;
      if ($urandom % 2 == 0) ins[31:28] = 4'hE;
      if (!ins[25] && ($urandom % 4 != 0)) ins[4] = 1'b0;
      if ($urandom % 8 == 0) rf[$urandom % 16] = ($urandom % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      if ($urandom % 8 == 0) ins[3:0] = ins[19:16];
      run(($urandom % 10) != 0, ins, "R2/R3/R5/R6/R7 random");
    end
    summary();
    $finish;
  end
endmodule